// File: doc/BRIEF.md
# Protection Entry Register File with Locking

This block stores the control state of a memory-protection unit. It holds one configuration byte and one address register for each protection entry, and it also holds a machine security register. Software reaches all of this through a single-port register interface. That interface has a write strobe, a register index, write data and combinational read data.

Configuration bytes are packed several to a register word. Every write passes through a set of lock rules before it reaches storage, and a write that fails those rules is dropped without any error. Each entry's configuration byte and address register are exported on flat buses for the range decoder and the permission checker.

The block raises a one-cycle notice on `prot_changed_o` when a stored entry value really changes. Downstream lookup caches use that notice to invalidate themselves.

Top module: `prot_csr_file`

## Requirements
- R1: Index map: `csr_idx[7:6]` selects the group (0 configuration, 1 address, 2 security, 3 unused) and `csr_idx[5:0]` is the register number n. Byte i (bits 8i+7:8i) of configuration register n belongs to entry 4n+i. Configuration byte bits: 0 read, 1 write, 2 execute, 4:3 match mode (0 off, 1 top-of-range, 2 4-byte, 3 power-of-two). Bit 7 is the lock. Bits 6:5 are always stored and read as zero.
- R2: With lockdown and bypass both clear, a configuration byte is written only if its entry's lock bit is clear.
- R3: A write to address register k is dropped when entry k is locked. Lock bypass does not lift this.
- R4: A write to address register k is also dropped when entry k+1 is locked with match mode 1. The last entry has no such neighbour check.
- R5: With lockdown set and bypass clear, a configuration byte is accepted in two cases, whatever the entry's current lock. It is accepted when it sets the lock bit with execute clear. It is also accepted when the lock bit is clear and bits 2:0 differ from 3'b110.
- R6: With bypass set, every configuration byte write to an implemented entry is accepted.
- R7: Security register: bit 0 lockdown, bit 1 default-deny policy, bit 2 lock bypass, other bits zero. Bypass cannot go from 0 to 1 while any entry's lock bit is set; the written bit is then taken as 0.
- R8: Lockdown and default-deny are sticky: once set, only reset clears them.
- R9: Writes to entries at or above NUM_ENTRIES, and writes to group 3, change nothing. Reads of them return zero.
- R10: `prot_changed_o` is high for the cycle after a write edge that changed a stored configuration byte or address register, and low otherwise. Security-register writes do not raise it.
- R11: Reset (synchronous, active low) clears every entry and the security register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_we | input | 1 | Write strobe |
| csr_idx | input | 8 | Register index (group in 7:6, number in 5:0) |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for `csr_idx` (combinational) |
| cfg_bytes_o | output | 8*NUM_ENTRIES | Configuration byte of entry e at bits 8e+7:8e |
| addr_regs_o | output | XLEN*NUM_ENTRIES | Address register of entry e at slice e |
| sec_lockdown_o | output | 1 | Lockdown bit |
| sec_deny_default_o | output | 1 | Default-deny policy bit |
| sec_lock_bypass_o | output | 1 | Lock bypass bit |
| prot_changed_o | output | 1 | One-cycle notice that entry state changed |

## Verification
Directed sequences exercise each lock path on its own, so that a wrong rule shows up as a specific surviving or missing value:
- a locked entry under plain mode;
- a locked top-of-range neighbour of an address register;
- the last entry;
- bypass set before and after locking;
- lockdown's two acceptance shapes against the execute-only and write+execute rejects.

Sticky-bit and out-of-range writes confirm that state is kept. Repeated identical writes separate a real change from a mere write on the change notice. Constrained random traffic then mixes sparse lock bits, occasional security writes and mid-run resets. This reaches interactions of bypass, lockdown and neighbour locks that the directed cases do not line up.

// File: rtl/prot_csr_pkg.sv
// Shared constants and helpers for the protection register file.
// Assumes the byte layout and index map stated in the brief.
package prot_csr_pkg;

    typedef enum logic [1:0] {
        GRP_CFG  = 2'd0,
        GRP_ADDR = 2'd1,
        GRP_SEC  = 2'd2,
        GRP_NONE = 2'd3
    } csr_grp_e;

    localparam int          LOCK_BIT      = 7;
    localparam int          EXEC_BIT      = 2;
    localparam int          MODE_LO       = 3;
    localparam logic [1:0]  MODE_TOP      = 2'd1;
    localparam logic [7:0]  CFG_KEEP_MASK = 8'h9F;
    localparam logic [2:0]  PERM_WX       = 3'b110;
    localparam int          ENT_PER_SLOT  = 4;

    // Acceptance test applied to a new byte while lockdown is active.
    function automatic logic lockdown_accepts(logic [7:0] v);
        return (v[LOCK_BIT] && !v[EXEC_BIT]) ||
               (!v[LOCK_BIT] && (v[2:0] != PERM_WX));
    endfunction

endpackage

// File: rtl/prot_entry_reg.sv
// One protection entry: configuration byte plus address register.
// Applies the lock rules to each write and reports a real change.
// Assumes at most one of cfg_we_i / addr_we_i is high in a cycle.
module prot_entry_reg
    import prot_csr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we_i,
    input  logic [7:0]      cfg_wbyte_i,
    input  logic            addr_we_i,
    input  logic [XLEN-1:0] addr_wdata_i,
    input  logic            next_lock_top_i,
    input  logic            lockdown_i,
    input  logic            bypass_i,
    output logic [7:0]      cfg_q,
    output logic [XLEN-1:0] addr_q,
    output logic            changed_o
);

    logic [7:0] cfg_new;
    logic       cfg_ok;
    logic       addr_ok;

    // Decide whether each kind of write may land.
    always_comb begin
        cfg_new = cfg_wbyte_i & CFG_KEEP_MASK;
        if (bypass_i)        cfg_ok = 1'b1;
        else if (lockdown_i) cfg_ok = lockdown_accepts(cfg_new);
        else                 cfg_ok = !cfg_q[LOCK_BIT];
        addr_ok = !cfg_q[LOCK_BIT] && !next_lock_top_i;
    end

    // Storage update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            addr_q <= '0;
        end else begin
            if (cfg_we_i && cfg_ok)   cfg_q  <= cfg_new;
            if (addr_we_i && addr_ok) addr_q <= addr_wdata_i;
        end
    end

    // Flag a write that actually alters stored state.
    assign changed_o = (cfg_we_i && cfg_ok && (cfg_new != cfg_q)) ||
                       (addr_we_i && addr_ok && (addr_wdata_i != addr_q));

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[6:5] == 2'b00); // R1
    AST_PLAIN_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[LOCK_BIT] && !bypass_i && !lockdown_i) |=> $stable(cfg_q)); // R2
    AST_ADDR_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[LOCK_BIT] |=> $stable(addr_q)); // R3
    AST_NEIGHBOUR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        next_lock_top_i |=> $stable(addr_q)); // R4

endmodule

// File: rtl/prot_sec_reg.sv
// Machine security register: sticky lockdown and default-deny bits,
// and a lock-bypass bit that cannot rise while any entry is locked.
module prot_sec_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [2:0] wbits_i,
    input  logic       any_locked_i,
    output logic       lockdown_q,
    output logic       deny_default_q,
    output logic       bypass_q
);

    // Sticky set for bits 0/1, guarded update for bit 2.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lockdown_q     <= 1'b0;
            deny_default_q <= 1'b0;
            bypass_q       <= 1'b0;
        end else if (we_i) begin
            lockdown_q     <= lockdown_q | wbits_i[0];
            deny_default_q <= deny_default_q | wbits_i[1];
            bypass_q       <= wbits_i[2] & (bypass_q | !any_locked_i);
        end
    end

    AST_BYPASS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_q && any_locked_i) |=> !bypass_q); // R7
    AST_LOCKDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        lockdown_q |=> lockdown_q); // R8
    AST_DENY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        deny_default_q |=> deny_default_q); // R8

endmodule

// File: rtl/prot_csr_rmux.sv
// Read path: packs configuration bytes into words, selects address
// registers and the security word; unimplemented indices give zero.
module prot_csr_rmux
    import prot_csr_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16,
    parameter int NUM_W       = 6
) (
    input  csr_grp_e                    grp_i,
    input  logic [NUM_W-1:0]            num_i,
    input  logic [8*NUM_ENTRIES-1:0]    cfg_flat_i,
    input  logic [XLEN*NUM_ENTRIES-1:0] addr_flat_i,
    input  logic [2:0]                  sec_i,
    output logic [XLEN-1:0]             rdata_o
);

    localparam int BPC = XLEN / 8;

    // Combinational read selection.
    always_comb begin
        rdata_o = '0;
        unique case (grp_i)
            GRP_CFG: begin
                for (int i = 0; i < BPC; i++) begin
                    if (int'(num_i) * ENT_PER_SLOT + i < NUM_ENTRIES)
                        rdata_o[i*8 +: 8] =
                            cfg_flat_i[(int'(num_i) * ENT_PER_SLOT + i) * 8 +: 8];
                end
            end
            GRP_ADDR: begin
                if (int'(num_i) < NUM_ENTRIES)
                    rdata_o = addr_flat_i[int'(num_i) * XLEN +: XLEN];
            end
            GRP_SEC:  rdata_o = XLEN'(sec_i);
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/prot_csr_file.sv
// Top of the protection register file. Decodes the register index,
// routes bytes to entries, chains neighbour lock state for address
// writes, and registers the change notice. Assumes XLEN is 32 or 64.
module prot_csr_file
    import prot_csr_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        csr_we,
    input  logic [IDX_W-1:0]            csr_idx,
    input  logic [XLEN-1:0]             csr_wdata,
    output logic [XLEN-1:0]             csr_rdata,
    output logic [8*NUM_ENTRIES-1:0]    cfg_bytes_o,
    output logic [XLEN*NUM_ENTRIES-1:0] addr_regs_o,
    output logic                        sec_lockdown_o,
    output logic                        sec_deny_default_o,
    output logic                        sec_lock_bypass_o,
    output logic                        prot_changed_o
);

    localparam int NUM_W = IDX_W - 2;
    localparam int BPC   = XLEN / 8;

    csr_grp_e         grp;
    logic [NUM_W-1:0] num;
    logic [7:0]       cfg_arr   [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] ent_chg;
    logic [NUM_ENTRIES-1:0] lock_vec;
    logic             any_locked;
    logic             chg_q;

    assign grp = csr_grp_e'(csr_idx[IDX_W-1 -: 2]);
    assign num = csr_idx[NUM_W-1:0];

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        localparam int ENT = e;
        logic       cfg_we_e;
        logic [7:0] cfg_byte_e;
        logic       addr_we_e;
        logic       next_lt_e;

        // Find which byte lane of the addressed word holds this entry.
        always_comb begin
            cfg_we_e   = 1'b0;
            cfg_byte_e = '0;
            for (int i = 0; i < BPC; i++) begin
                if (int'(num) * ENT_PER_SLOT + i == ENT) begin
                    cfg_we_e   = csr_we && (grp == GRP_CFG);
                    cfg_byte_e = csr_wdata[i*8 +: 8];
                end
            end
            addr_we_e = csr_we && (grp == GRP_ADDR) && (int'(num) == ENT);
        end

        if (e + 1 < NUM_ENTRIES) begin : g_next
            assign next_lt_e = cfg_arr[e+1][LOCK_BIT] &&
                               (cfg_arr[e+1][MODE_LO +: 2] == MODE_TOP);
        end else begin : g_last
            assign next_lt_e = 1'b0;
        end

        prot_entry_reg #(.XLEN(XLEN)) u_ent (
            .clk            (clk),
            .rst_n          (rst_n),
            .cfg_we_i       (cfg_we_e),
            .cfg_wbyte_i    (cfg_byte_e),
            .addr_we_i      (addr_we_e),
            .addr_wdata_i   (csr_wdata),
            .next_lock_top_i(next_lt_e),
            .lockdown_i     (sec_lockdown_o),
            .bypass_i       (sec_lock_bypass_o),
            .cfg_q          (cfg_arr[e]),
            .addr_q         (addr_regs_o[e*XLEN +: XLEN]),
            .changed_o      (ent_chg[e])
        );

        assign cfg_bytes_o[e*8 +: 8] = cfg_arr[e];
        assign lock_vec[e]           = cfg_arr[e][LOCK_BIT];
    end

    assign any_locked = |lock_vec;

    prot_sec_reg u_sec (
        .clk           (clk),
        .rst_n         (rst_n),
        .we_i          (csr_we && (grp == GRP_SEC)),
        .wbits_i       (csr_wdata[2:0]),
        .any_locked_i  (any_locked),
        .lockdown_q    (sec_lockdown_o),
        .deny_default_q(sec_deny_default_o),
        .bypass_q      (sec_lock_bypass_o)
    );

    prot_csr_rmux #(.XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES), .NUM_W(NUM_W)) u_rmux (
        .grp_i      (grp),
        .num_i      (num),
        .cfg_flat_i (cfg_bytes_o),
        .addr_flat_i(addr_regs_o),
        .sec_i      ({sec_lock_bypass_o, sec_deny_default_o, sec_lockdown_o}),
        .rdata_o    (csr_rdata)
    );

    // Register the change notice so it is a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) chg_q <= 1'b0;
        else        chg_q <= |ent_chg;
    end
    assign prot_changed_o = chg_q;

    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> !prot_changed_o); // R10
    AST_OOR_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp == GRP_ADDR) && (int'(num) >= NUM_ENTRIES)) |-> (csr_rdata == '0)); // R9
    AST_SPARE_GRP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == GRP_NONE) |-> (csr_rdata == '0)); // R9

endmodule

// File: tb/sim_prot_csr_file.sv
module sim_prot_csr_file;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              csr_we = 1'b0;
    logic [7:0]        csr_idx = '0;
    logic [31:0]       csr_wdata = '0;
    logic [31:0]       csr_rdata;
    logic [8*N-1:0]    cfg_bytes_o;
    logic [32*N-1:0]   addr_regs_o;
    logic              sec_lockdown_o, sec_deny_default_o, sec_lock_bypass_o;
    logic              prot_changed_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [7:0]  m_cfg  [N];
    logic [31:0] m_addr [N];
    bit m_lock, m_deny, m_byp;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_csr_file u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_idx(csr_idx),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .cfg_bytes_o(cfg_bytes_o), .addr_regs_o(addr_regs_o),
        .sec_lockdown_o(sec_lockdown_o), .sec_deny_default_o(sec_deny_default_o),
        .sec_lock_bypass_o(sec_lock_bypass_o), .prot_changed_o(prot_changed_o)
    );

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic void mdl_reset();
        for (int e = 0; e < N; e++) begin
            m_cfg[e] = '0;
            m_addr[e] = '0;
        end
        m_lock = 0; m_deny = 0; m_byp = 0;
    endfunction

    // Reference model of one write; returns whether entry state changed.
    function automatic bit mdl_write(logic [7:0] idx, logic [31:0] d);
        bit chg = 0;
        int n = int'(idx[5:0]);
        case (idx[7:6])
            2'd0: for (int i = 0; i < 4; i++) begin
                int e = n * 4 + i;
                if (e < N) begin
                    logic [7:0] v = d[i*8 +: 8] & 8'h9F;
                    bit ok;
                    if (m_byp) ok = 1;
                    else if (m_lock) ok = (v[7] && !v[2]) || (!v[7] && v[2:0] != 3'b110);
                    else ok = !m_cfg[e][7];
                    if (ok) begin
                        if (v != m_cfg[e]) chg = 1;
                        m_cfg[e] = v;
                    end
                end
            end
            2'd1: if (n < N) begin
                bit ok = !m_cfg[n][7];
                if (n + 1 < N && m_cfg[n+1][7] && m_cfg[n+1][4:3] == 2'd1) ok = 0;
                if (ok) begin
                    if (d != m_addr[n]) chg = 1;
                    m_addr[n] = d;
                end
            end
            2'd2: begin
                bit anyl = 0;
                for (int e = 0; e < N; e++) if (m_cfg[e][7]) anyl = 1;
                m_byp  = d[2] && (m_byp || !anyl);
                m_lock = m_lock || d[0];
                m_deny = m_deny || d[1];
            end
            default: ;
        endcase
        return chg;
    endfunction

    function automatic logic [31:0] mdl_read(logic [7:0] idx);
        logic [31:0] r = '0;
        int n = int'(idx[5:0]);
        case (idx[7:6])
            2'd0: for (int i = 0; i < 4; i++)
                      if (n * 4 + i < N) r[i*8 +: 8] = m_cfg[n*4+i];
            2'd1: if (n < N) r = m_addr[n];
            2'd2: r = {29'd0, m_byp, m_deny, m_lock};
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        csr_we = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        mdl_reset();
    endtask

    // Write, then check the change notice in the following cycle (R10).
    task automatic wr(logic [7:0] idx, logic [31:0] d, string tag);
        bit exp;
        @(negedge clk);
        csr_we = 1; csr_idx = idx; csr_wdata = d;
        exp = mdl_write(idx, d);
        @(negedge clk);
        csr_we = 0;
        chk(prot_changed_o == exp, {tag, " R10 change notice"},
            32'(prot_changed_o), 32'(exp));
    endtask

    task automatic rd(logic [7:0] idx, string tag);
        csr_idx = idx;
        #1;
        chk(csr_rdata == mdl_read(idx), tag, csr_rdata, mdl_read(idx));
    endtask

    task automatic rd_exp(logic [7:0] idx, logic [31:0] exp, string tag);
        csr_idx = idx;
        #1;
        chk(csr_rdata == exp, tag, csr_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        mdl_reset();
        do_reset();

        // R11: everything zero after reset
        for (int n = 0; n < 4; n++) rd_exp(8'(n), 32'h0, "R11 cfg reset");
        for (int k = 0; k < N; k++) rd_exp(8'h40 | 8'(k), 32'h0, "R11 addr reset");
        rd_exp(8'h80, 32'h0, "R11 sec reset");
        chk(prot_changed_o == 1'b0, "R11 notice reset", 32'(prot_changed_o), 0);

        // R1: packing and reserved bits; entry1 = locked top-of-range
        wr(8'h00, 32'h1B6F8801, "R1");
        rd_exp(8'h00, 32'h1B0F8801, "R1 cfg packing");
        chk(cfg_bytes_o[15:8] == 8'h88, "R1 entry1 export", 32'(cfg_bytes_o[15:8]), 32'h88);
        wr(8'h41, 32'h0000_1000, "R3");
        rd_exp(8'h41, 32'h0, "R3 locked addr kept");
        wr(8'h40, 32'h0000_0100, "R4");
        rd_exp(8'h40, 32'h0, "R4 neighbour lock blocks");
        wr(8'h42, 32'h0000_0200, "R4");
        rd_exp(8'h42, 32'h200, "R4 unlocked addr written");
        wr(8'h4F, 32'hCAFE_0000, "R4");
        rd_exp(8'h4F, 32'hCAFE_0000, "R4 last entry written");
        wr(8'h00, 32'h0, "R2");
        rd_exp(8'h00, 32'h0000_8800, "R2 locked byte kept");
        wr(8'h00, 32'h0, "R10 repeat write no change");
        wr(8'h80, 32'h4, "R7");
        rd_exp(8'h80, 32'h0, "R7 bypass refused while locked");

        // R6: bypass set before any lock
        do_reset();
        wr(8'h80, 32'h4, "R6");
        rd_exp(8'h80, 32'h4, "R6 bypass set");
        wr(8'h00, 32'h80, "R6");
        wr(8'h00, 32'h0, "R6");
        rd_exp(8'h00, 32'h0, "R6 locked byte rewritten");
        wr(8'h00, 32'h80, "R6");
        wr(8'h80, 32'h0, "R7");
        wr(8'h80, 32'h4, "R7");
        rd_exp(8'h80, 32'h0, "R7 bypass cannot rise again");

        // R8 and R5: lockdown
        do_reset();
        wr(8'h80, 32'h3, "R8");
        wr(8'h80, 32'h0, "R8");
        rd_exp(8'h80, 32'h3, "R8 sticky bits");
        wr(8'h00, 32'h05068483, "R5");
        rd_exp(8'h00, 32'h05000083, "R5 lockdown accept/reject");
        wr(8'h00, 32'h00000081, "R5");
        rd_exp(8'h00, 32'h00000081, "R5 locked entry rewritten under lockdown");

        // R9: out-of-range and spare group
        wr(8'h04, 32'hFFFF_FFFF, "R9");
        rd_exp(8'h04, 32'h0, "R9 cfg beyond entries");
        wr(8'h54, 32'h1234_5678, "R9");
        rd_exp(8'h54, 32'h0, "R9 addr beyond entries");
        wr(8'hC0, 32'hFFFF_FFFF, "R9");
        rd_exp(8'hC0, 32'h0, "R9 spare group");
        rd_exp(8'h00, 32'h00000081, "R9 entries untouched");

        // Random traffic against the model
        do_reset();
        for (int it = 0; it < 1200; it++) begin
            logic [7:0]  idx;
            logic [31:0] d;
            int sel = int'($urandom % 16);
            if (it % 150 == 149) do_reset();
            if (sel == 0) begin
                idx = 8'h80;
                d = {29'd0, 1'($urandom), ($urandom % 8) == 0, ($urandom % 6) == 0};
            end else if (sel < 8) begin
                idx = 8'($urandom % 6);
                d = $urandom & ~(32'h80808080 & ~($urandom & $urandom & $urandom));
            end else if (sel < 15) begin
                idx = 8'h40 | 8'($urandom % 20);
                d = $urandom;
            end else begin
                idx = 8'hC0 | 8'($urandom % 64);
                d = $urandom;
            end
            wr(idx, d, "R10 random");
            rd(idx, "R1 R2 R3 R4 R5 R6 R7 R8 R9 random readback");
            rd(8'(($urandom % 3) << 6) | 8'($urandom % 18), "R1 R4 random cross read");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule